// File: doc/BRIEF.md
# SDRAM Open-Row Command Sequencer

This block turns a stream of read and write requests into the command sequence of a four-bank SDRAM. Each request names a bank, a row, a starting column and an identifier. The sequencer keeps a table of the row held open in each bank. A request to a bank with no open row gets an ACTIVATE. A request whose row is already open goes straight to the column command. A request to a bank holding a different row first gets a PRECHARGE to that bank. Every command goes out in the earliest cycle that the row-to-column delay, the precharge time and the burst spacing allow.

Only one request is handled at a time. The sequencer accepts the next request as soon as the current one has issued its column command. The next request's PRECHARGE or ACTIVATE can therefore go out while the previous burst is still on the data bus, so bursts to different banks run back to back. For reads, the sequencer marks the cycles in which the device drives data. It passes the device data through with a valid flag and the identifier of the request that issued the READ. Power-up initialisation, refresh and the pad interface are outside this block.

Top module: `sdram_seq`

## Requirements
- R1: After reset the command output is NOP, `rd_valid` is low, `req_ready` is high and every bank is treated as having no open row.
- R2: A request to a bank with no open row issues ACTIVATE with that bank and with the row on `cmd_addr`, in the cycle after acceptance. Its column command follows no sooner than `T_RCD` cycles after the ACTIVATE.
- R3: The column command carries the request's bank and has its column zero-extended on `cmd_addr`. It is READ for a read request and WRITE for a write request.
- R4: A request whose row is already open in its bank issues no ACTIVATE or PRECHARGE. Its column command comes in the cycle after acceptance unless the R6 spacing holds it back.
- R5: A request to a bank holding a different row issues PRECHARGE to that bank, with `cmd_addr` zero. ACTIVATE for the new row follows exactly `T_RP` cycles later.
- R6: Two column commands are at least `BURST_LEN` cycles apart. A PRECHARGE is at least `BURST_LEN` cycles after the most recent column command.
- R7: Every command issues in the earliest cycle allowed by R2 to R6, and NOP is driven in all other cycles. An ACTIVATE for the next request may therefore fall inside the previous request's data burst.
- R8: For a READ issued in cycle t, `rd_valid` is high in cycles t+`CAS_LAT` through t+`CAS_LAT`+`BURST_LEN`-1 and in no other cycle. In those cycles `rd_id` equals the request identifier and `rd_data` equals `dev_dq`. A WRITE raises no `rd_valid`.
- R9: `req_ready` is high only while no request is in progress. It rises again in the cycle after the current request's column command.
- R10: `cmd_code` is {RAS#, CAS#, WE#}: NOP 3'b111, ACTIVATE 3'b011, READ 3'b101, WRITE 3'b100, PRECHARGE 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column of the burst |
| req_id | input | ID_W | Identifier returned with read data |
| cmd_code | output | 3 | Command encoding {RAS#, CAS#, WE#} |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row for ACTIVATE, column for READ/WRITE, zero for PRECHARGE |
| dev_dq | input | DQ_W | Data driven by the device |
| rd_valid | output | 1 | A read beat is present |
| rd_id | output | ID_W | Identifier of the read the beat belongs to |
| rd_data | output | DQ_W | Read beat data |

## Verification
The bench targets three kinds of request that decide the command sequence:
- a row hit straight after a conflict in the same bank;
- a conflict that arrives while the previous burst still holds the column spacing;
- back-to-back requests to different banks, where the ACTIVATE must fall inside the running burst.

A sequencer that got the open-row table wrong would emit a spare ACTIVATE on a hit, or drop a PRECHARGE on a conflict. One whose timers were off by a cycle would shift the column command or clip the burst. One that stalled the ACTIVATE behind the burst would leave gaps between bursts. The bench also checks that the read identifier and the beat window match the right READ when bursts abut, and that writes never raise the read flag.

// File: rtl/sdram_seq_pkg.sv
// Shared types for the SDRAM command sequencer.
// Assumes the conventional {RAS#, CAS#, WE#} command encoding.
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_WR  = 3'b100,
        CMD_PRE = 3'b010
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_WAIT,
        ST_COL
    } seq_state_e;

endpackage

// File: rtl/sdram_row_table.sv
// Open-row table: one valid flag and one row per bank.
// Looks up the requested bank combinationally. ACTIVATE opens a row and
// PRECHARGE closes it. Assumes ACTIVATE and PRECHARGE never coincide.
module sdram_row_table #(
    parameter int N_BANKS = 4,
    parameter int ROW_W   = 13,
    localparam int BANK_W = $clog2(N_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_open,
    output logic              lk_hit,
    input  logic              act_en,
    input  logic              pre_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row
);

    logic [N_BANKS-1:0]            open_v;
    logic [N_BANKS-1:0][ROW_W-1:0] open_r;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic             v_q;
        logic [ROW_W-1:0] r_q;

        // Track the open row of bank b
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                r_q <= '0;
            end else if (act_en && upd_bank == BANK_W'(b)) begin
                v_q <= 1'b1;
                r_q <= upd_row;
            end else if (pre_en && upd_bank == BANK_W'(b)) begin
                v_q <= 1'b0;
            end
        end

        assign open_v[b] = v_q;
        assign open_r[b] = r_q;
    end

    // Classify the looked-up request
    always_comb begin
        lk_open = open_v[lk_bank];
        lk_hit  = lk_open && (open_r[lk_bank] == lk_row);
    end

endmodule

// File: rtl/sdram_col_spacer.sv
// Column spacing timer. After a column command it holds col_ok low for
// BURST_LEN-1 cycles, so the next column command or PRECHARGE comes at
// least BURST_LEN cycles later.
module sdram_col_spacer #(
    parameter int BURST_LEN = 4,
    localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_fire,
    output logic col_ok
);

    logic [CNT_W-1:0] cnt_q;

    // Count down the cycles left until the data bus is free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (col_fire) begin
            cnt_q <= CNT_W'(BURST_LEN - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign col_ok = (cnt_q == '0);

endmodule

// File: rtl/sdram_rd_return.sv
// Read return. Delays each READ by CAS_LAT cycles, then marks BURST_LEN
// consecutive beats and tags them with the read's identifier.
// Assumes READs are at least BURST_LEN cycles apart.
module sdram_rd_return #(
    parameter int ID_W      = 4,
    parameter int DQ_W      = 16,
    parameter int CAS_LAT   = 2,
    parameter int BURST_LEN = 4,
    localparam int BEAT_W   = $clog2(BURST_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_fire,
    input  logic [ID_W-1:0] fire_id,
    input  logic [DQ_W-1:0] dev_dq,
    output logic            rd_valid,
    output logic [ID_W-1:0] rd_id,
    output logic [DQ_W-1:0] rd_data
);

    logic [CAS_LAT-1:0] pipe_v;
    logic [ID_W-1:0]    pipe_id [CAS_LAT];
    logic [BEAT_W-1:0]  beats_left;
    logic [ID_W-1:0]    hold_id;
    logic               head_v;

    assign head_v = pipe_v[CAS_LAT-1];

    // Shift issued reads through the CAS latency line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_v <= '0;
            for (int k = 0; k < CAS_LAT; k++) pipe_id[k] <= '0;
        end else begin
            pipe_v[0]  <= rd_fire;
            pipe_id[0] <= fire_id;
            for (int k = 1; k < CAS_LAT; k++) begin
                pipe_v[k]  <= pipe_v[k-1];
                pipe_id[k] <= pipe_id[k-1];
            end
        end
    end

    // Hold the burst open for the beats after the first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_left <= '0;
            hold_id    <= '0;
        end else if (head_v) begin
            beats_left <= BEAT_W'(BURST_LEN - 1);
            hold_id    <= pipe_id[CAS_LAT-1];
        end else if (beats_left != '0) begin
            beats_left <= beats_left - 1'b1;
        end
    end

    // Drive the read beat outputs
    always_comb begin
        rd_valid = head_v || (beats_left != '0);
        rd_id    = head_v ? pipe_id[CAS_LAT-1] : hold_id;
        rd_data  = rd_valid ? dev_dq : '0;
    end

endmodule

// File: rtl/sdram_seq.sv
// SDRAM open-row command sequencer. Takes one request at a time and issues
// PRECHARGE / ACTIVATE / column command as the open-row table requires,
// each at the earliest legal cycle. It assumes every timing parameter is
// at least 1 and that the device is already initialised.
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int N_BANKS   = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int ID_W      = 4,
    parameter int DQ_W      = 16,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int CAS_LAT   = 2,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = $clog2(N_BANKS),
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [ID_W-1:0]   req_id,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic [DQ_W-1:0]   dev_dq,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_id,
    output logic [DQ_W-1:0]   rd_data
);

    localparam int TMAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int TMR_W = $clog2(TMAX + 1);

    seq_state_e        state_q, after_q;
    logic [TMR_W-1:0]  wait_q;
    logic              cur_write;
    logic [BANK_W-1:0] cur_bank;
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic [ID_W-1:0]   cur_id;

    logic       accept, lk_open, lk_hit, col_ok;
    logic       pre_fire, act_fire, col_fire;
    sdram_cmd_e cmd_e;

    sdram_row_table #(.N_BANKS(N_BANKS), .ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_bank  (req_bank),
        .lk_row   (req_row),
        .lk_open  (lk_open),
        .lk_hit   (lk_hit),
        .act_en   (act_fire),
        .pre_en   (pre_fire),
        .upd_bank (cur_bank),
        .upd_row  (cur_row)
    );

    sdram_col_spacer #(.BURST_LEN(BURST_LEN)) u_space (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_fire (col_fire),
        .col_ok   (col_ok)
    );

    sdram_rd_return #(
        .ID_W(ID_W), .DQ_W(DQ_W), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)
    ) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (col_fire && !cur_write),
        .fire_id  (cur_id),
        .dev_dq   (dev_dq),
        .rd_valid (rd_valid),
        .rd_id    (rd_id),
        .rd_data  (rd_data)
    );

    // Decide which command may go out this cycle
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
        pre_fire  = (state_q == ST_PRE) && col_ok;
        act_fire  = (state_q == ST_ACT);
        col_fire  = (state_q == ST_COL) && col_ok;
    end

    // Drive the command bus
    always_comb begin
        cmd_e    = CMD_NOP;
        cmd_addr = '0;
        if (pre_fire) begin
            cmd_e = CMD_PRE;
        end else if (act_fire) begin
            cmd_e    = CMD_ACT;
            cmd_addr = ADDR_W'(cur_row);
        end else if (col_fire) begin
            cmd_e    = cur_write ? CMD_WR : CMD_RD;
            cmd_addr = ADDR_W'(cur_col);
        end
        cmd_code = cmd_e;
        cmd_bank = cur_bank;
    end

    // Latch the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_bank  <= '0;
            cur_row   <= '0;
            cur_col   <= '0;
            cur_id    <= '0;
        end else if (accept) begin
            cur_write <= req_write;
            cur_bank  <= req_bank;
            cur_row   <= req_row;
            cur_col   <= req_col;
            cur_id    <= req_id;
        end
    end

    // Step through precharge, activate, delay and column phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            after_q <= ST_IDLE;
            wait_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    if (lk_hit)       state_q <= ST_COL;
                    else if (lk_open) state_q <= ST_PRE;
                    else              state_q <= ST_ACT;
                end
                ST_PRE: if (pre_fire) begin
                    if (T_RP == 1) begin
                        state_q <= ST_ACT;
                    end else begin
                        state_q <= ST_WAIT;
                        after_q <= ST_ACT;
                        wait_q  <= TMR_W'(T_RP - 1);
                    end
                end
                ST_ACT: begin
                    if (T_RCD == 1) begin
                        state_q <= ST_COL;
                    end else begin
                        state_q <= ST_WAIT;
                        after_q <= ST_COL;
                        wait_q  <= TMR_W'(T_RCD - 1);
                    end
                end
                ST_WAIT: begin
                    if (wait_q <= TMR_W'(1)) state_q <= after_q;
                    else                     wait_q  <= wait_q - 1'b1;
                end
                ST_COL: if (col_fire) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_seq_chk.sv
// Timing checker for the sequencer. It keeps its own counters of the
// cycles since each kind of command and checks spacing at the ports.
module sdram_seq_chk #(
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int CAS_LAT   = 2,
    parameter int BURST_LEN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cmd_code,
    input logic       req_ready,
    input logic       rd_valid
);

    localparam int        GW  = 8;
    localparam logic [GW-1:0] SAT = '1;

    logic [GW-1:0] since_col, since_act, since_pre, since_rd;
    logic [2:0]    last_cmd;
    logic          is_nop, is_act, is_pre, is_col;

    assign is_nop = (cmd_code == 3'b111);
    assign is_act = (cmd_code == 3'b011);
    assign is_pre = (cmd_code == 3'b010);
    assign is_col = (cmd_code == 3'b101) || (cmd_code == 3'b100);

    // Count cycles since each command class, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_col <= SAT;
            since_act <= SAT;
            since_pre <= SAT;
            since_rd  <= SAT;
            last_cmd  <= 3'b111;
        end else begin
            since_col <= is_col ? GW'(1) : (since_col == SAT ? SAT : since_col + 1'b1);
            since_act <= is_act ? GW'(1) : (since_act == SAT ? SAT : since_act + 1'b1);
            since_pre <= is_pre ? GW'(1) : (since_pre == SAT ? SAT : since_pre + 1'b1);
            since_rd  <= (cmd_code == 3'b101) ? GW'(1) : (since_rd == SAT ? SAT : since_rd + 1'b1);
            if (!is_nop) last_cmd <= cmd_code;
        end
    end

    AST_COL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> since_col >= GW'(BURST_LEN)); // R6
    AST_PRE_AFTER_COL: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> since_col >= GW'(BURST_LEN)); // R6
    AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && last_cmd == 3'b011) |-> since_act >= GW'(T_RCD)); // R2
    AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && last_cmd == 3'b010) |-> since_pre == GW'(T_RP)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> is_nop); // R9
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop || is_act || is_pre || is_col); // R10
    AST_BEAT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ((CAS_LAT <= BURST_LEN) && $rose(rd_valid)) |-> since_rd == GW'(CAS_LAT)); // R8

endmodule

bind sdram_seq sdram_seq_chk #(
    .T_RCD(T_RCD), .T_RP(T_RP), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_code  (cmd_code),
    .req_ready (req_ready),
    .rd_valid  (rd_valid)
);

// File: tb/sim_sdram_seq.sv
`timescale 1ns/1ps
// Bench for the SDRAM sequencer: a cycle schedule predicted from the
// requirements, compared against the ports every cycle.
module sim_sdram_seq;

    localparam int NB = 4, RW = 13, CW = 10, IW = 4, DW = 16;
    localparam int TRCD = 2, TRP = 2, CL = 2, BL = 4, RING = 64;
    localparam int C_NOP = 7, C_ACT = 3, C_RD = 5, C_WR = 4, C_PRE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [1:0]    req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [IW-1:0] req_id = '0;
    logic [2:0]    cmd_code;
    logic [1:0]    cmd_bank;
    logic [12:0]   cmd_addr;
    logic [DW-1:0] dev_dq = '0;
    logic          rd_valid;
    logic [IW-1:0] rd_id;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;

    sdram_seq #(
        .N_BANKS(NB), .ROW_W(RW), .COL_W(CW), .ID_W(IW), .DQ_W(DW),
        .T_RCD(TRCD), .T_RP(TRP), .CAS_LAT(CL), .BURST_LEN(BL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_id(req_id), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .dev_dq(dev_dq),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_data(rd_data)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int ex_cmd [RING], ex_bank [RING], ex_addr [RING], ex_tag [RING];
    bit ex_rd [RING];
    int ex_rdid [RING];
    bit mv [NB];
    int mr [NB];
    int last_col = -1000, busy_until = -1;

    // Cycle counter and device data pattern
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
        dev_dq <= DW'(cyc * 29 + 11);
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_name(int t);
        case (t)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic put(int c, int code, int bank, int addr, int tag);
        ex_cmd[c % RING]  = code;
        ex_bank[c % RING] = bank;
        ex_addr[c % RING] = addr;
        ex_tag[c % RING]  = tag;
    endtask

    // Predict the command schedule of a request accepted in cycle a
    task automatic schedule(int a);
        int b, act, pre, col, tag;
        b = int'(req_bank);
        tag = 3;
        if (mv[b] && mr[b] == int'(req_row)) begin
            col = imax(a + 1, last_col + BL);
            tag = (col > a + 1) ? 6 : 4;
        end else begin
            if (mv[b]) begin
                pre = imax(a + 1, last_col + BL);
                put(pre, C_PRE, b, 0, (pre > a + 1) ? 6 : 5);
                act = pre + TRP;
                put(act, C_ACT, b, int'(req_row), 5);
            end else begin
                act = a + 1;
                put(act, C_ACT, b, int'(req_row), 2);
            end
            col = imax(act + TRCD, last_col + BL);
            if (col > act + TRCD) tag = 6;
        end
        put(col, req_write ? C_WR : C_RD, b, int'(req_col), tag);
        if (!req_write)
            for (int k = 0; k < BL; k++) begin
                ex_rd[(col + CL + k) % RING]   = 1'b1;
                ex_rdid[(col + CL + k) % RING] = int'(req_id);
            end
        mv[b] = 1'b1;
        mr[b] = int'(req_row);
        last_col = col;
        busy_until = col;
    endtask

    // Per-cycle monitor, sampled away from the clock edge
    always @(negedge clk) begin : mon
        int s;
        if (rst_n) begin
            s = cyc % RING;
            chk(req_ready == (cyc > busy_until), "R9", "req_ready",
                int'(req_ready), int'(cyc > busy_until));
            if (req_valid && req_ready) schedule(cyc);
            chk(int'(cmd_code) == ex_cmd[s], tag_name(ex_tag[s]), "cmd_code",
                int'(cmd_code), ex_cmd[s]);
            if (ex_cmd[s] != C_NOP) begin
                chk(int'(cmd_bank) == ex_bank[s], "R3", "cmd_bank", int'(cmd_bank), ex_bank[s]);
                chk(int'(cmd_addr) == ex_addr[s], tag_name(ex_tag[s]), "cmd_addr",
                    int'(cmd_addr), ex_addr[s]);
            end
            if (cmd_code != 3'b111)
                chk(cmd_code inside {3'b011, 3'b101, 3'b100, 3'b010}, "R10", "cmd legal",
                    int'(cmd_code), C_ACT);
            chk(rd_valid == ex_rd[s], "R8", "rd_valid", int'(rd_valid), int'(ex_rd[s]));
            if (ex_rd[s]) begin
                chk(int'(rd_id) == ex_rdid[s], "R8", "rd_id", int'(rd_id), ex_rdid[s]);
                chk(rd_data == dev_dq, "R8", "rd_data", int'(rd_data), int'(dev_dq));
            end
            ex_cmd[s] = C_NOP;
            ex_tag[s] = 7;
            ex_rd[s]  = 1'b0;
        end
    end

    // Offer one request and hold it until it is taken
    task automatic send(bit wr, int bank, int row, int col, int id);
        req_valid = 1'b1;
        req_write = wr;
        req_bank  = 2'(bank);
        req_row   = RW'(row);
        req_col   = CW'(col);
        req_id    = IW'(id);
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        finish_run();
    end

    // Stimulus
    initial begin
        int id;
        void'($urandom(32'd4711));
        for (int i = 0; i < RING; i++) begin
            ex_cmd[i] = C_NOP; ex_tag[i] = 7; ex_rd[i] = 1'b0;
        end
        for (int i = 0; i < NB; i++) begin
            mv[i] = 1'b0; mr[i] = 0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_code == 3'b111 && req_ready && !rd_valid, "R1", "reset state",
            int'({cmd_code, req_ready, rd_valid}), int'({3'b111, 1'b1, 1'b0}));
        @(posedge clk);
        #1;
        // Directed: empty bank, hit, conflict, back-to-back other banks
        send(1'b0, 0, 5, 3, 1);    // R2 empty bank
        send(1'b0, 0, 5, 7, 2);    // R4 hit held by spacing
        send(1'b0, 0, 9, 1, 3);    // R5 conflict
        send(1'b0, 1, 2, 4, 4);    // R7 activate inside burst
        send(1'b1, 2, 3, 8, 5);    // R3 write
        send(1'b1, 3, 4, 9, 6);
        send(1'b0, 3, 4, 10, 7);   // R4 hit after write
        idle(12);
        send(1'b0, 1, 2, 11, 8);   // R4 hit from idle
        idle(3);
        send(1'b1, 1, 7, 12, 9);   // R5 conflict from idle
        idle(10);
        // Random mix with a small row set for hits and conflicts
        id = 10;
        for (int n = 0; n < 400; n++) begin
            send(1'($urandom % 2), int'($urandom % NB), int'($urandom % 3),
                 int'($urandom % 1024), id);
            id++;
            if (($urandom % 4) == 0) idle(int'($urandom % 6));
        end
        idle(30);
        finish_run();
    end

endmodule